// File: doc/BRIEF.md
# Packed Q15 Rounding Multiply-High Unit

This block is a single-stage SIMD datapath. It treats two wide operand vectors as arrays of signed 16-bit lanes. For every lane it forms the signed 32-bit product of the two operands. It shifts the product arithmetically right by 14 and adds one to round. It then keeps bits 16 down to 1 of the rounded value as the 16-bit lane result. This is the usual Q15 fixed-point rounding multiply. No saturation is applied, so the one overflowing input pair wraps.

A 2-bit length code selects how many lanes take part: 8, 16 or 32 lanes. A per-lane mask chooses which active lanes receive the computed value. Lanes that are not selected either keep the matching lane of an old-destination vector (merge) or are written as zero (zero-fill). Lanes at or above the selected length are always cleared. The result is registered: operands presented with `inValid` appear at the outputs one clock later, together with `outValid`.

Top module: `q15_mulhr_unit`

## Requirements
- R1: Each active, selected lane i (bits [16*i+15:16*i], lane 0 at bit 0) produces bits [16:1] of ((a*b) >>> 14) + 1, where a and b are the signed 16-bit lanes of `srcA` and `srcB`.
- R2: No saturation is applied. 0x8000 times 0x8000 gives 0x8000.
- R3: `vecLen` 2'b00 selects 8 lanes, 2'b01 selects 16 lanes and 2'b10 selects 32 lanes. The undefined code 2'b11 behaves as 8 lanes.
- R4: Every result lane at or above the selected lane count is zero, whatever the mask, mode and old destination.
- R5: With `maskEn` low, every active lane is computed and `laneMask` has no effect.
- R6: With `maskEn` high and `zeroMode` low, an active lane whose `laneMask` bit is 0 outputs the matching lane of `oldDst`.
- R7: With `maskEn` high and `zeroMode` high, an active lane whose `laneMask` bit is 0 outputs zero.
- R8: `outValid` is high exactly one clock after a cycle with `inValid` high and low otherwise. `result` holds its value after a cycle with `inValid` low.
- R9: Synchronous active-high `rst` clears `outValid` and `result` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands are valid this cycle |
| srcA | input | 512 | First operand vector, 32 lanes of 16 bits |
| srcB | input | 512 | Second operand vector |
| oldDst | input | 512 | Previous destination, used for merged lanes |
| laneMask | input | 32 | Per-lane write select, bit i for lane i |
| maskEn | input | 1 | 1: apply laneMask; 0: write all active lanes |
| zeroMode | input | 1 | 1: unselected lanes are zeroed; 0: merged |
| vecLen | input | 2 | Length code: 00=8, 01=16, 10=32 lanes, 11=8 |
| outValid | output | 1 | Result is valid |
| result | output | 512 | Registered lane results |

## Verification
The assertions assume that the inputs carry known values at every rising edge. They also assume that `oldDst`, the mask and the mode are sampled in the same cycle as `inValid`, since the checks compare `result` with `$past` of those inputs. The bench changes all inputs only on the falling edge, so each set of operands is stable across the edge that captures it. Every transaction pairs a strobe with fully defined vectors built from random words and a few fixed corner values: the most negative operand, zero, and an all-clear or alternating mask. The merge and zero-fill assertions are therefore only armed by well-formed stimulus.

// File: rtl/q15_pkg.sv
package q15_pkg;
  localparam int LANE_W    = 16;
  localparam int MAX_LANES = 32;
  localparam int VEC_W     = LANE_W * MAX_LANES;
  localparam int LEN_W     = 2;

  typedef enum logic [LEN_W-1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_FULL  = 2'b10,
    LEN_RSV   = 2'b11
  } len_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic                 load;
    logic [MAX_LANES-1:0] active;
    logic [MAX_LANES-1:0] compute;
    logic                 zeroFill;
  } ctrl_t;
endpackage

// File: rtl/q15_lane.sv
module q15_lane #(
  parameter int W     = 16,
  parameter int SHIFT = 14
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] laneOut
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] extA, extB, product, scaled, rounded;

  always_comb begin
    extA    = PW'(signed'(opA));
    extB    = PW'(signed'(opB));
    product = extA * extB;
    scaled  = product >>> SHIFT;
    rounded = scaled + PW'(1);
    laneOut = rounded[W:1];
  end

  // R2: the single overflowing pair wraps rather than saturating
  always_comb begin
    if (opA == {1'b1, {(W-1){1'b0}}} && opB == {1'b1, {(W-1){1'b0}}}) begin
      p_wrap_no_sat_r2: assert (laneOut == {1'b1, {(W-1){1'b0}}});
    end
  end
endmodule

// File: rtl/q15_ctrl.sv
module q15_ctrl
  import q15_pkg::*;
(
  input  logic                 inValid,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic [LEN_W-1:0]     vecLen,
  output ctrl_t                ctrl
);
  localparam int LANES_SHORT = 128 / LANE_W;
  localparam int LANES_MID   = 256 / LANE_W;
  localparam int LANES_FULL  = 512 / LANE_W;
  localparam int CNT_W       = $clog2(MAX_LANES + 1);

  logic [CNT_W-1:0] laneCount;

  // R3: reserved code falls back to the short length
  always_comb begin
    unique case (len_e'(vecLen))
      LEN_MID:  laneCount = CNT_W'(LANES_MID);
      LEN_FULL: laneCount = CNT_W'(LANES_FULL);
      default:  laneCount = CNT_W'(LANES_SHORT);
    endcase
  end

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    always_comb begin
      ctrl.active[i]  = (CNT_W'(i) < laneCount);
      ctrl.compute[i] = ctrl.active[i] & (~maskEn | laneMask[i]);
    end
  end

  always_comb begin
    ctrl.load     = inValid;
    ctrl.zeroFill = zeroMode;
  end
endmodule

// File: rtl/q15_datapath.sv
module q15_datapath
  import q15_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [VEC_W-1:0] oldDst,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] nextVec;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [LANE_W-1:0] prod;

    q15_lane #(.W(LANE_W), .SHIFT(LANE_W - 2)) u_lane (
      .opA    (srcA[i*LANE_W +: LANE_W]),
      .opB    (srcB[i*LANE_W +: LANE_W]),
      .laneOut(prod)
    );

    always_comb begin
      if (!ctrl.active[i])      nextVec[i*LANE_W +: LANE_W] = '0;
      else if (ctrl.compute[i]) nextVec[i*LANE_W +: LANE_W] = prod;
      else if (ctrl.zeroFill)   nextVec[i*LANE_W +: LANE_W] = '0;
      else                      nextVec[i*LANE_W +: LANE_W] = oldDst[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) result <= nextVec;
    end
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> outValid);

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> (!outValid && $stable(result)));
endmodule

// File: rtl/q15_mulhr_unit.sv
module q15_mulhr_unit
  import q15_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [VEC_W-1:0]     oldDst,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  input  logic [LEN_W-1:0]     vecLen,
  output logic                 outValid,
  output logic [VEC_W-1:0]     result
);
  localparam int MID_BITS = 256;

  ctrl_t ctrl;

  q15_ctrl u_ctrl (
    .inValid (inValid),
    .laneMask(laneMask),
    .maskEn  (maskEn),
    .zeroMode(zeroMode),
    .vecLen  (vecLen),
    .ctrl    (ctrl)
  );

  q15_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .srcA    (srcA),
    .srcB    (srcB),
    .oldDst  (oldDst),
    .outValid(outValid),
    .result  (result)
  );

  p_upper_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && vecLen != LEN_FULL) |=> (result[VEC_W-1:MID_BITS] == '0));

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && maskEn && zeroMode && laneMask == '0) |=> (result == '0));

  p_merge_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && maskEn && !zeroMode && laneMask == '0 && vecLen == LEN_FULL)
      |=> (result == $past(oldDst)));
endmodule

// File: tb/q15_mulhr_unit_bench.sv
module q15_mulhr_unit_bench;
  localparam int LW = 16;
  localparam int NL = 32;
  localparam int VW = LW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [VW-1:0] srcA = '0, srcB = '0, oldDst = '0;
  logic [NL-1:0] laneMask = '0;
  logic maskEn = 1'b0, zeroMode = 1'b0;
  logic [1:0] vecLen = 2'b00;
  logic outValid;
  logic [VW-1:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  q15_mulhr_unit u_q15_mulhr_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .oldDst(oldDst), .laneMask(laneMask), .maskEn(maskEn), .zeroMode(zeroMode),
    .vecLen(vecLen), .outValid(outValid), .result(result)
  );

  function automatic logic [LW-1:0] laneRef(logic [LW-1:0] a, logic [LW-1:0] b);
    longint pa, pb, p;
    pa = longint'(signed'(a));
    pb = longint'(signed'(b));
    p  = ((pa * pb) >>> 14) + 1;
    return LW'(p >>> 1);
  endfunction

  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
      logic [VW-1:0] old, logic [NL-1:0] m, logic me, logic zm, logic [1:0] len);
    logic [VW-1:0] r;
    int lanes;
    lanes = (len == 2'b01) ? 16 : (len == 2'b10) ? 32 : 8;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      if (i >= lanes)          r[i*LW +: LW] = '0;
      else if (!me || m[i])    r[i*LW +: LW] = laneRef(a[i*LW +: LW], b[i*LW +: LW]);
      else if (zm)             r[i*LW +: LW] = '0;
      else                     r[i*LW +: LW] = old[i*LW +: LW];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rndVec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one transaction at a falling edge, sample at the next falling edge
  task automatic apply(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] old,
      logic [NL-1:0] m, logic me, logic zm, logic [1:0] len, string req);
    @(negedge clk);
    srcA = a; srcB = b; oldDst = old; laneMask = m;
    maskEn = me; zeroMode = zm; vecLen = len; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, VW'(outValid), VW'(1));
    check(req, result, model(a, b, old, m, me, zm, len));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 reset valid", VW'(outValid), VW'(0));
    check("R9 reset data", result, '0);
  endtask

  task automatic t_arith();
    logic [VW-1:0] a, b;
    a = '0; b = '0;
    a[0 +: LW]  = 16'h4000; b[0 +: LW]  = 16'h4000;
    a[16 +: LW] = 16'hC000; b[16 +: LW] = 16'h4000;
    a[32 +: LW] = 16'h7FFF; b[32 +: LW] = 16'h7FFF;
    a[48 +: LW] = 16'h0001; b[48 +: LW] = 16'hFFFF;
    apply(a, b, rndVec(), '0, 1'b0, 1'b0, 2'b10, "R1 fixed");
    for (int k = 0; k < 4; k++)
      apply(rndVec(), rndVec(), rndVec(), '0, 1'b0, 1'b0, 2'b10, "R1 random");
  endtask

  task automatic t_wrap();
    apply({NL{16'h8000}}, {NL{16'h8000}}, '0, '0, 1'b0, 1'b0, 2'b10, "R2 wrap");
    check("R2 lane0", VW'(result[LW-1:0]), VW'(16'h8000));
  endtask

  task automatic t_lengths();
    for (int l = 0; l < 4; l++) begin
      apply(rndVec(), rndVec(), rndVec(), '1, 1'b1, 1'b0, 2'(l), "R3 length");
      if (l != 2) check("R4 upper zero", VW'(result[VW-1:256]), '0);
    end
    apply(rndVec(), rndVec(), rndVec(), 32'h5A5A_A5A5, 1'b1, 1'b0, 2'b00, "R4 merge above len");
    check("R4 bits above 128", VW'(result[VW-1:128]), '0);
  endtask

  task automatic t_nomask();
    apply(rndVec(), rndVec(), rndVec(), '0, 1'b0, 1'b1, 2'b10, "R5 mask ignored");
    apply(rndVec(), rndVec(), rndVec(), 32'h0F0F_0F0F, 1'b0, 1'b0, 2'b01, "R5 mask ignored mid");
  endtask

  task automatic t_merge();
    logic [VW-1:0] old;
    old = rndVec();
    apply(rndVec(), rndVec(), old, '0, 1'b1, 1'b0, 2'b10, "R6 all kept");
    check("R6 equals old", result, old);
    apply(rndVec(), rndVec(), rndVec(), 32'hAAAA_5555, 1'b1, 1'b0, 2'b10, "R6 alternating");
  endtask

  task automatic t_zero();
    apply(rndVec(), rndVec(), rndVec(), '0, 1'b1, 1'b1, 2'b10, "R7 all zero");
    check("R7 equals zero", result, '0);
    apply(rndVec(), rndVec(), rndVec(), 32'h1234_8765, 1'b1, 1'b1, 2'b01, "R7 partial");
  endtask

  task automatic t_latency();
    logic [VW-1:0] held;
    apply(rndVec(), rndVec(), rndVec(), '0, 1'b0, 1'b0, 2'b10, "R8 load");
    held = result;
    srcA = rndVec(); srcB = rndVec();
    @(negedge clk);
    check("R8 valid drops", VW'(outValid), VW'(0));
    check("R8 result held", result, held);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset again valid", VW'(outValid), VW'(0));
    check("R9 reset again data", result, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_arith();
    t_wrap();
    t_lengths();
    t_nomask();
    t_merge();
    t_zero();
    t_latency();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule